// File: doc/BRIEF.md
# Single-Wire Client Bit-Frame Front End

This block is the client-side physical layer of a single-wire, host-timed serial link on which one line carries both power and data and is pulled high externally. The host begins every bit frame by pulling the line low. The block spots that falling edge and times the rest of the frame from it in system clock cycles. In an input frame it samples the line at a fixed point to decide whether the host sent a 0 or a 1. In an output frame it answers a 0 by holding the line low for a while after the host lets go, and it answers a 1 by leaving the line alone.

Around the bit frames it also tracks the line-level events that frame a transaction. A long low period resets the link. After a reset, the line must stay high for a recovery time, and the first host pulse after that is a discovery request: the client answers it with a long low pulse of its own. A long high period marks a start or stop condition. A short idle gap lets the stream carry on where it paused. The transaction layer above sees a one-cycle strobe per received bit, a start/stop strobe, a reset strobe and a link-up level. For each frame it supplies a transmit bit and an output-mode select, both ahead of the frame's falling edge. The block drives an open-drain pull-down enable.

Top module: `sline_client_fe`

## Requirements
- R1: After `rst_n` is released, `line_pull`, `link_up`, `rx_valid`, `gap_seen` and `reset_seen` are all 0, and the block waits for line recovery.
- R2: In an input frame (`tx_mode`=0 at the falling edge), the synchronized line is sampled `T_SAMPLE` cycles after the edge is registered. A low sample gives `rx_bit`=0 and a high sample gives 1, and `rx_valid` pulses for exactly one cycle per frame.
- R3: In an output frame (`tx_mode`=1 at the falling edge), `tx_bit`=0 asserts `line_pull` for exactly `T_HOLD0` cycles, starting the cycle after the edge is registered. `tx_bit`=1 never asserts `line_pull`. The frame's `rx_valid` strobe reports the wire level seen at the sample point, which is the bit that was sent.
- R4: A line held low for `T_RESET` cycles or more causes one `reset_seen` pulse, releases `line_pull` and drops `link_up`, whatever state the block is in. A low period shorter than `T_RESET` causes no reset.
- R5: After reset or power-up, the line must stay high for `T_RECOV` cycles before a falling edge is taken as discovery. A host pulse that arrives earlier is ignored: it causes no pull, and it restarts the recovery count.
- R6: The first falling edge after recovery is answered by asserting `line_pull` for exactly `T_DACK` cycles. `link_up` then goes to 1, and the discovery frame produces no `rx_valid`.
- R7: While the link is up, a high period of `T_GAP` cycles or more produces exactly one `gap_seen` pulse. A high period of `T_GAP`-1 cycles produces none. If a high period of exactly `T_GAP` cycles ends in a host falling edge, the start/stop strobe and the new frame's decoding both happen.
- R8: An idle gap shorter than `T_GAP` does not break the stream: the next frame decodes normally and no start/stop is reported.
- R9: `rx_valid` never pulses while `link_up` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Raw level of the shared line (1 = high) |
| line_pull | output | 1 | Open-drain enable: 1 pulls the line low |
| tx_mode | input | 1 | 1 selects an output frame for the next falling edge |
| tx_bit | input | 1 | Bit sent in the next output frame |
| rx_valid | output | 1 | One-cycle strobe, one per decoded frame |
| rx_bit | output | 1 | Bit value decoded in the frame, valid when `rx_valid` is 1 |
| gap_seen | output | 1 | One-cycle start/stop condition strobe |
| reset_seen | output | 1 | One-cycle line-reset strobe |
| link_up | output | 1 | 1 once discovery has been answered and until the next reset |

## Verification
The start/stop detector and the frame-start detector can act in the same cycle. This happens when the host ends a high period of exactly `T_GAP` cycles with a new falling edge, so that the high-run count reaches the threshold in the same cycle the edge is registered. The bench provokes this with input frames separated by gaps of exactly `T_GAP`-1 and exactly `T_GAP` cycles. It judges the outcome by counting start/stop strobes (zero and one respectively) and by checking that the bit of the following frame still decodes correctly in both cases.

// File: rtl/sline_pkg.sv
// sline_pkg: shared types and helpers for the single-wire client front end.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sline_pkg;

    // Link/frame state of the client front end
    typedef enum logic [2:0] {
        ST_RECOV = 3'd0,   // waiting for the line to stay high after reset
        ST_DISCW = 3'd1,   // waiting for the discovery request edge
        ST_DACK  = 3'd2,   // driving the discovery answer
        ST_IDLE  = 3'd3,   // link up, waiting for a frame edge
        ST_FRAME = 3'd4    // inside a bit frame
    } fe_state_t;

    // Larger of two integers, used to size counters
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sline_sync.sv
// sline_sync: brings the asynchronous line level into the clock domain.
// Assumes the line idles high; the reset value is 1 so that no edge is seen
// at reset. STAGES picks the depth; a depth of 1 gives a single register.
module sline_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            // Single capture register
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b1;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            // Shift chain of capture registers
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sline_runcnt.sv
// sline_runcnt: saturating run-length counter.
// restart loads 1, clear loads 0, otherwise the count climbs and holds at LIM.
// Assumes LIM fits in CW bits.
module sline_runcnt #(
    parameter int CW  = 8,
    parameter int LIM = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          restart,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] K_LIM = CW'(LIM);
    localparam logic [CW-1:0] K_ONE = CW'(1);

    // Count consecutive qualifying cycles, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (restart)       cnt <= K_ONE;
        else if (clear)         cnt <= '0;
        else if (cnt != K_LIM)  cnt <= cnt + K_ONE;
    end

endmodule

// File: rtl/sline_timer.sv
// sline_timer: measures the synchronized line.
// It gives a falling-edge flag, the cycles elapsed since the last edge, and
// threshold hits for the low run (reset) and high run (start/stop, recovery).
// Assumes LIM exceeds every threshold, so each "==" hit fires once per run.
module sline_timer #(
    parameter int CW      = 8,
    parameter int LIM     = 201,
    parameter int T_RESET = 200,
    parameter int T_GAP   = 100,
    parameter int T_RECOV = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ln,
    output logic          fall,
    output logic [CW-1:0] elap,
    output logic          rst_hit,
    output logic          gap_hit,
    output logic          recov_ok
);

    localparam logic [CW-1:0] K_RESET = CW'(T_RESET);
    localparam logic [CW-1:0] K_GAP   = CW'(T_GAP);
    localparam logic [CW-1:0] K_RECOV = CW'(T_RECOV);

    logic          ln_prev;
    logic [CW-1:0] low_cnt;
    logic [CW-1:0] high_cnt;

    // Remember the previous line level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ln_prev <= 1'b1;
        else        ln_prev <= ln;
    end

    assign fall = ln_prev & ~ln;

    // Low run length
    sline_runcnt #(.CW(CW), .LIM(LIM)) u_low (
        .clk(clk), .rst_n(rst_n), .clear(ln), .restart(1'b0), .cnt(low_cnt)
    );

    // High run length
    sline_runcnt #(.CW(CW), .LIM(LIM)) u_high (
        .clk(clk), .rst_n(rst_n), .clear(~ln), .restart(1'b0), .cnt(high_cnt)
    );

    // Cycles since the last falling edge
    sline_runcnt #(.CW(CW), .LIM(LIM)) u_elap (
        .clk(clk), .rst_n(rst_n), .clear(1'b0), .restart(fall), .cnt(elap)
    );

    assign rst_hit  = (low_cnt == K_RESET);
    assign gap_hit  = (high_cnt == K_GAP);
    assign recov_ok = (high_cnt >= K_RECOV);

endmodule

// File: rtl/sline_frame_fsm.sv
// sline_frame_fsm: link and bit-frame control.
// It handles recovery, the discovery answer, input sampling, output pull-down
// and the strobes toward the transaction layer. A line reset takes priority
// over everything else. Assumes T_SAMPLE < T_HOLD0 and T_DACK, T_HOLD0 < T_RESET.
module sline_frame_fsm
    import sline_pkg::*;
#(
    parameter int CW       = 8,
    parameter int T_SAMPLE = 20,
    parameter int T_HOLD0  = 40,
    parameter int T_DACK   = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ln,
    input  logic          fall,
    input  logic [CW-1:0] elap,
    input  logic          rst_hit,
    input  logic          gap_hit,
    input  logic          recov_ok,
    input  logic          tx_mode,
    input  logic          tx_bit,
    output logic          pull,
    output logic          rx_valid,
    output logic          rx_bit,
    output logic          gap_seen,
    output logic          reset_seen,
    output logic          link_up
);

    localparam logic [CW-1:0] K_SAMPLE = CW'(T_SAMPLE);
    localparam logic [CW-1:0] K_HOLD0  = CW'(T_HOLD0);
    localparam logic [CW-1:0] K_DACK   = CW'(T_DACK);

    fe_state_t state;

    // State sequencing, line drive and one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RECOV;
            pull       <= 1'b0;
            rx_valid   <= 1'b0;
            rx_bit     <= 1'b1;
            gap_seen   <= 1'b0;
            reset_seen <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            gap_seen   <= 1'b0;
            reset_seen <= 1'b0;
            if (rst_hit) begin
                state      <= ST_RECOV;
                pull       <= 1'b0;
                reset_seen <= 1'b1;
            end else begin
                case (state)
                    ST_RECOV: begin
                        if (recov_ok) state <= ST_DISCW;
                    end
                    ST_DISCW: begin
                        if (fall) begin
                            state <= ST_DACK;
                            pull  <= 1'b1;
                        end
                    end
                    ST_DACK: begin
                        if (elap == K_DACK) begin
                            pull  <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                    ST_IDLE: begin
                        gap_seen <= gap_hit;
                        if (fall) begin
                            state <= ST_FRAME;
                            pull  <= tx_mode & ~tx_bit;
                        end
                    end
                    ST_FRAME: begin
                        if (elap == K_SAMPLE) begin
                            rx_valid <= 1'b1;
                            rx_bit   <= ln;
                        end
                        if (elap == K_HOLD0) begin
                            pull  <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_RECOV;
                endcase
            end
        end
    end

    assign link_up = (state == ST_IDLE) || (state == ST_FRAME);

endmodule

// File: rtl/sline_client_fe.sv
// sline_client_fe: single-wire client bit-frame front end (top).
// It synchronizes the line, measures runs and edges, and runs the frame FSM.
// Assumes an external pull-up on the line and that line_pull drives an
// open-drain pull-down. All thresholds are in clk cycles.
module sline_client_fe
    import sline_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int T_SAMPLE    = 20,
    parameter int T_HOLD0     = 40,
    parameter int T_DACK      = 60,
    parameter int T_RESET     = 200,
    parameter int T_RECOV     = 50,
    parameter int T_GAP       = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_pull,
    input  logic tx_mode,
    input  logic tx_bit,
    output logic rx_valid,
    output logic rx_bit,
    output logic gap_seen,
    output logic reset_seen,
    output logic link_up
);

    localparam int LIM = imax(imax(T_RESET, T_GAP),
                              imax(T_RECOV, imax(T_DACK, imax(T_HOLD0, T_SAMPLE)))) + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic          ln;
    logic          fall;
    logic [CW-1:0] elap;
    logic          rst_hit;
    logic          gap_hit;
    logic          recov_ok;

    sline_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(ln)
    );

    sline_timer #(
        .CW(CW), .LIM(LIM), .T_RESET(T_RESET), .T_GAP(T_GAP), .T_RECOV(T_RECOV)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .ln(ln), .fall(fall), .elap(elap),
        .rst_hit(rst_hit), .gap_hit(gap_hit), .recov_ok(recov_ok)
    );

    sline_frame_fsm #(
        .CW(CW), .T_SAMPLE(T_SAMPLE), .T_HOLD0(T_HOLD0), .T_DACK(T_DACK)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ln(ln), .fall(fall), .elap(elap),
        .rst_hit(rst_hit), .gap_hit(gap_hit), .recov_ok(recov_ok),
        .tx_mode(tx_mode), .tx_bit(tx_bit), .pull(line_pull),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .gap_seen(gap_seen),
        .reset_seen(reset_seen), .link_up(link_up)
    );

endmodule

// File: rtl/sline_client_fe_chk.sv
// sline_client_fe_chk: protocol checker bound to sline_client_fe.
// It watches only ports, plus run counters kept inside the checker itself.
module sline_client_fe_chk
    import sline_pkg::*;
#(
    parameter int T_HOLD0 = 40,
    parameter int T_DACK  = 60,
    parameter int T_GAP   = 100
) (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic line_pull,
    input logic rx_valid,
    input logic gap_seen,
    input logic reset_seen,
    input logic link_up
);

    localparam int MAXP = imax(T_DACK, T_HOLD0);
    localparam int RW   = $clog2(imax(MAXP, T_GAP) + 2);
    localparam logic [RW-1:0] K_MAXP = RW'(MAXP);
    localparam logic [RW-1:0] K_GAP  = RW'(T_GAP);
    localparam logic [RW-1:0] K_ONE  = RW'(1);

    logic [RW-1:0] pull_run;
    logic [RW-1:0] hi_run;
    logic [RW-1:0] hi_prev;

    // Length of the current pull-down run, saturating just past the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                    pull_run <= '0;
        else if (!line_pull)           pull_run <= '0;
        else if (pull_run <= K_MAXP)   pull_run <= pull_run + K_ONE;
    end

    // Raw high run length and the length of the previous high run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run  <= '0;
            hi_prev <= '0;
        end else if (line_in) begin
            if (hi_run < K_GAP) hi_run <= hi_run + K_ONE;
        end else begin
            if (hi_run != '0) hi_prev <= hi_run;
            hi_run <= '0;
        end
    end

    // R2
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3
    pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run <= K_MAXP);

    // R4
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |-> (!line_pull && !link_up));

    // R4
    reset_vs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_seen && rx_valid));

    // R7
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_seen |-> (hi_run >= K_GAP || hi_prev >= K_GAP));

    // R9
    rx_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> link_up);

endmodule

bind sline_client_fe sline_client_fe_chk #(
    .T_HOLD0(T_HOLD0), .T_DACK(T_DACK), .T_GAP(T_GAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_pull(line_pull),
    .rx_valid(rx_valid), .gap_seen(gap_seen), .reset_seen(reset_seen),
    .link_up(link_up)
);

// File: tb/sline_client_fe_test.sv
// sline_client_fe_test: self-checking bench for the single-wire client front end.
// The wire is modelled as pulled high unless the host or the client pulls it low.
module sline_client_fe_test;

    localparam int T_SAMPLE = 20;
    localparam int T_HOLD0  = 40;
    localparam int T_DACK   = 60;
    localparam int T_RESET  = 200;
    localparam int T_RECOV  = 50;
    localparam int T_GAP    = 100;

    typedef struct packed {
        logic       txm;
        logic       txb;
        logic [7:0] low;
        logic [9:0] gap;
        logic       expb;
        logic       exps;
    } vec_t;

    // Frame table: mode, tx bit, host low cycles, gap cycles, expected bit, expected start/stop
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 8'd5,  10'd200, 1'b1, 1'b1},
        '{1'b0, 1'b1, 8'd30, 10'd50,  1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd8,  10'd200, 1'b0, 1'b1},
        '{1'b1, 1'b1, 8'd8,  10'd50,  1'b1, 1'b0},
        '{1'b0, 1'b0, 8'd5,  10'd50,  1'b1, 1'b0},
        '{1'b1, 1'b0, 8'd8,  10'd50,  1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd30, 10'd200, 1'b0, 1'b1},
        '{1'b1, 1'b1, 8'd8,  10'd200, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic tx_mode = 1'b0;
    logic tx_bit = 1'b1;
    logic line_in;
    logic line_pull, rx_valid, rx_bit, gap_seen, reset_seen, link_up;

    assign line_in = ~(host_low | line_pull);

    always #5 clk = ~clk;

    sline_client_fe #(
        .SYNC_STAGES(2), .T_SAMPLE(T_SAMPLE), .T_HOLD0(T_HOLD0), .T_DACK(T_DACK),
        .T_RESET(T_RESET), .T_RECOV(T_RECOV), .T_GAP(T_GAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_pull(line_pull),
        .tx_mode(tx_mode), .tx_bit(tx_bit), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .gap_seen(gap_seen), .reset_seen(reset_seen), .link_up(link_up)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int rx_cnt = 0, rx_last = -1, ss_cnt = 0, rs_cnt = 0;
    int pull_rises = 0, pull_run = 0, pull_last = 0;
    logic pull_prev = 1'b0;

    // Output monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_valid)   begin rx_cnt++; rx_last = int'(rx_bit); end
        if (gap_seen)   ss_cnt++;
        if (reset_seen) rs_cnt++;
        if (line_pull) begin
            if (!pull_prev) pull_rises++;
            pull_run++;
        end else if (pull_prev) begin
            pull_last = pull_run;
            pull_run  = 0;
        end
        pull_prev = line_pull;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int low);
        host_low = 1'b1;
        repeat (low) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic frame(input logic m, input logic b, input int low, input int gap);
        tx_mode = m;
        tx_bit  = b;
        pulse(low);
        idle(gap);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int r0, s0, p0, k0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 line_pull", int'(line_pull), 0);
        check("R1 link_up", int'(link_up), 0);
        check("R1 strobes", int'(rx_valid | gap_seen | reset_seen), 0);

        // R5 early pulse during recovery is ignored
        idle(20);
        pulse(10);
        idle(80);
        check("R5 no pull on early pulse", pull_rises, 0);
        check("R5 link still down", int'(link_up), 0);

        // R6 discovery answer, R9 no frame reported
        r0 = rx_cnt;
        pulse(10);
        idle(100);
        check("R6 discovery pull length", pull_last, T_DACK);
        check("R6 link up", int'(link_up), 1);
        check("R9 no rx during discovery", rx_cnt - r0, 0);

        // R2 R3 R7 R8 table walk
        for (int i = 0; i < 8; i++) begin
            r0 = rx_cnt; s0 = ss_cnt; p0 = pull_rises;
            frame(VECS[i].txm, VECS[i].txb, int'(VECS[i].low), int'(VECS[i].gap));
            check($sformatf("R2 rx count v%0d", i), rx_cnt - r0, 1);
            check($sformatf("R2/R3 rx bit v%0d", i), rx_last, int'(VECS[i].expb));
            check($sformatf("R7/R8 start-stop v%0d", i), ss_cnt - s0, int'(VECS[i].exps));
            if (VECS[i].txm) begin
                check($sformatf("R3 pull count v%0d", i), pull_rises - p0, VECS[i].txb ? 0 : 1);
                if (!VECS[i].txb)
                    check($sformatf("R3 hold length v%0d", i), pull_last, T_HOLD0);
            end
        end

        // R7 gap one short of the threshold, then a frame
        tx_mode = 1'b0;
        s0 = ss_cnt; r0 = rx_cnt;
        frame(1'b0, 1'b1, 5, T_GAP - 1);
        frame(1'b0, 1'b1, 30, 50);
        check("R7 gap T_GAP-1 no strobe", ss_cnt - s0, 0);
        check("R8 bits after short gap", rx_cnt - r0, 2);
        check("R8 last bit after short gap", rx_last, 0);

        // R7 gap exactly at threshold coincides with the next falling edge
        s0 = ss_cnt; r0 = rx_cnt;
        frame(1'b0, 1'b1, 5, T_GAP);
        frame(1'b0, 1'b1, 30, 50);
        check("R7 gap T_GAP with edge strobe", ss_cnt - s0, 1);
        check("R7 bits with coincident edge", rx_cnt - r0, 2);
        check("R7 bit after coincident edge", rx_last, 0);

        // R4 long low below the reset threshold
        k0 = rs_cnt;
        frame(1'b0, 1'b1, T_RESET - 50, 100);
        check("R4 no reset below threshold", rs_cnt - k0, 0);
        check("R4 link kept", int'(link_up), 1);
        check("R2 long low decodes 0", rx_last, 0);

        // R4 reset from idle
        k0 = rs_cnt;
        pulse(T_RESET + 50);
        idle(5);
        check("R4 reset strobe", rs_cnt - k0, 1);
        check("R4 link dropped", int'(link_up), 0);
        check("R4 pull released", int'(line_pull), 0);

        // R5 R6 rediscovery after reset
        idle(80);
        pulse(10);
        idle(100);
        check("R6 rediscovery pull length", pull_last, T_DACK);
        check("R6 link up again", int'(link_up), 1);

        // R4 reset in the middle of an output-0 frame
        k0 = rs_cnt;
        tx_mode = 1'b1; tx_bit = 1'b0;
        pulse(T_RESET + 50);
        idle(5);
        tx_mode = 1'b0;
        check("R4 reset during output frame", rs_cnt - k0, 1);
        check("R4 link dropped in frame", int'(link_up), 0);
        check("R4 no pull after reset", int'(line_pull), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule